// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave Model

This block is a synthesizable behavioural model of a 64-word by 16-bit serial EEPROM slave. A host talks to it over three wires: a chip select, a serial clock and a serial data input. Results come back on a serial data output. The output is tri-stateable, so it is modelled as a data bit plus an output enable. Each instruction starts with a start bit (a 1). After the start bit come a 2-bit opcode and a 6-bit word address, both shifted in MSB first. Write instructions then take 16 data bits.

Instructions that change the array do not complete in the same step. They only take effect when chip select falls after the final bit. That falling edge starts a self-timed busy period, which is counted in system clocks. While the busy period runs, raising chip select shows the busy/ready status on the output. The ready indication stays on the output until the host clocks in a new start bit.

All three serial inputs pass through synchronisers and are edge-detected in the system clock domain. The array is held in registers.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the data output enable is low, writing is disabled, no status is shown, and every word reads 0xFFFF.
- R2: READ (opcode 10) works whether writing is enabled or disabled. After the last address bit the output drives a dummy 0. On each following serial clock rise it then shifts out the 16 data bits, MSB first.
- R3: WRITE (opcode 01), with writing enabled, takes 16 data bits MSB first after the address. A chip-select fall after the last data bit stores the word, and a later READ returns it.
- R4: Opcode 00 with address bits [5:4]=11 enables writing, and with [5:4]=00 disables it. Each takes effect at the chip-select fall. While writing is disabled, WRITE, ERASE, ERASE-ALL and WRITE-ALL change nothing and start no busy period.
- R5: ERASE (opcode 11) sets the addressed word to 0xFFFF. Opcode 00 with [5:4]=10 sets every word to 0xFFFF. Opcode 00 with [5:4]=01, followed by 16 data bits, writes those bits to every word.
- R6: A programming operation keeps the block busy for PROG_CYCLES system clocks. While busy, chip select high makes the output drive 0. Serial clock and data activity is ignored, and chip select may toggle without disturbing the operation.
- R7: When the busy period ends, chip select high makes the output drive 1. This stays true across any number of chip-select toggles until a start bit is clocked in. That start bit clears the status and begins a new instruction.
- R8: While chip select is low, the data output enable is low.
- R9: If a serial clock rise follows the last bit of a programming instruction before chip select falls, the instruction is abandoned and nothing is programmed.
- R10: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, sampled on serial clock rise |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out enable (low means tri-state) |

## Verification
The assertions rely on three properties of the inputs:
- The serial clock is many system clocks slower than the system clock.
- Data in changes only while the serial clock is low.
- A programming launch therefore never coincides with an active busy period.

The stimulus holds each serial clock phase for six system clocks. It changes data in one phase ahead of each rise. It moves chip select only while the serial clock is low, so every edge passes through the synchronisers cleanly and in order.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_ARMED, ST_HOLD
  } mw_state_e;

  typedef enum logic [2:0] {
    PK_NONE, PK_WORD, PK_ALL, PK_WEN, PK_WDIS
  } mw_pend_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS = 2'b00;
  localparam logic [1:0] EX_WRAL = 2'b01;
  localparam logic [1:0] EX_ERAL = 2'b10;
  localparam logic [1:0] EX_WEN  = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !start_i;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WORDS  = 64,
  parameter int WIDTH  = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             all_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[i] <= '1;
      else if (all_i || (we_i && waddr_i == AW'(i)))    mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic cs_s, sk_s, di_s, cs_q, sk_q;
  logic cs_fall, sk_rise;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (.clk_i, .rst_ni, .d_i(cs_i), .q_o(cs_s));
  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_sk (.clk_i, .rst_ni, .d_i(sk_i), .q_o(sk_s));
  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_di (.clk_i, .rst_ni, .d_i(di_i), .q_o(di_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
    end
  end

  assign cs_fall = cs_q && !cs_s;
  assign sk_rise = sk_s && !sk_q;

  mw_state_e          state_q;
  mw_pend_e           pend_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q, addr_nx;
  logic [DATA_W-1:0]  data_q, rdata;
  logic [DATA_W:0]    out_sr_q;
  logic               wen_q, rdy_q;
  logic               busy, tmr_done, launch, prog_start, arr_we, arr_all;

  assign addr_nx    = {addr_q[ADDR_W-2:0], di_s};
  assign launch     = cs_fall && (state_q == ST_ARMED);
  assign prog_start = launch && wen_q && (pend_q == PK_WORD || pend_q == PK_ALL);
  assign arr_we     = prog_start && (pend_q == PK_WORD);
  assign arr_all    = prog_start && (pend_q == PK_ALL);

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy), .done_o(tmr_done)
  );

  mw_array #(.WORDS(WORDS), .WIDTH(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .we_i(arr_we), .all_i(arr_all), .waddr_i(addr_q), .wdata_i(data_q),
    .raddr_i(addr_nx), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= PK_NONE;
      cnt_q    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      out_sr_q <= '0;
      wen_q    <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      if (tmr_done) rdy_q <= 1'b1;
      if (!cs_s) begin
        state_q <= ST_IDLE;
        if (launch && pend_q == PK_WEN)  wen_q <= 1'b1;
        if (launch && pend_q == PK_WDIS) wen_q <= 1'b0;
      end else if (sk_rise && !busy) begin
        unique case (state_q)
          ST_IDLE: if (di_s) begin   // start bit; zeros before it are skipped
            state_q <= ST_OPC;
            cnt_q   <= '0;
            rdy_q   <= 1'b0;
          end
          ST_OPC: begin
            op_q <= {op_q[0], di_s};
            if (cnt_q == CNT_W'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_q <= '0;
              unique case (op_q)
                OP_READ: begin
                  out_sr_q <= {1'b0, rdata};
                  state_q  <= ST_READ;
                end
                OP_WRITE: begin
                  pend_q  <= PK_WORD;
                  state_q <= ST_DATA;
                end
                OP_ERASE: begin
                  pend_q  <= PK_WORD;
                  data_q  <= '1;
                  state_q <= ST_ARMED;
                end
                default: begin
                  unique case (addr_nx[ADDR_W-1 -: 2])
                    EX_WEN:  begin pend_q <= PK_WEN;  state_q <= ST_ARMED; end
                    EX_WDIS: begin pend_q <= PK_WDIS; state_q <= ST_ARMED; end
                    EX_ERAL: begin pend_q <= PK_ALL; data_q <= '1; state_q <= ST_ARMED; end
                    default: begin pend_q <= PK_ALL;  state_q <= ST_DATA;  end
                  endcase
                end
              endcase
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          ST_DATA: begin
            data_q <= {data_q[DATA_W-2:0], di_s};
            if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_ARMED;
            else cnt_q <= cnt_q + CNT_W'(1);
          end
          ST_READ:  out_sr_q <= {out_sr_q[DATA_W-1:0], 1'b0};
          ST_ARMED: state_q <= ST_HOLD;   // late clock edge abandons the instruction
          default:  ;
        endcase
      end
    end
  end

  assign do_oe_o = cs_s && (busy || rdy_q || state_q == ST_READ);
  assign do_o    = busy ? 1'b0 : (rdy_q ? 1'b1 : out_sr_q[DATA_W]);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     cs_s,
  input logic     do_o,
  input logic     do_oe_o,
  input logic     busy,
  input logic     rdy_q,
  input logic     wen_q,
  input logic     launch,
  input logic     prog_start,
  input mw_pend_e pend_q
);
  assert_tristate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_oe_o);

  assert_busy_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cs_s) |-> (do_oe_o && !do_o));

  assert_busy_follows_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |=> busy);

  assert_no_restart_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> !busy);

  assert_ready_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !busy && cs_s) |-> (do_oe_o && do_o));

  assert_ready_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> rdy_q);

  assert_no_prog_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> wen_q);

  assert_enable_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && pend_q == PK_WEN) |=> wen_q);

  assert_disable_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && pend_q == PK_WDIS) |=> !wen_q);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .do_o(do_o), .do_oe_o(do_oe_o),
  .busy(busy), .rdy_q(rdy_q), .wen_q(wen_q), .launch(launch),
  .prog_start(prog_start), .pend_q(pend_q)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int PROG = 200;
  localparam int H    = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0;
  logic do_o, do_oe_o;
  int   n_run = 0, n_fail = 0;

  logic [15:0] exp_q[$], cap_q[$];
  string       tag_q[$];
  event        cap_ev;

  always #2 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk_i(clk), .rst_ni, .cs_i, .sk_i, .di_i, .do_o, .do_oe_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di_i = b; waitc(H);
    sk_i = 1'b1; waitc(H);
    sk_i = 1'b0;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input int lead);
    cs_i = 1'b1; waitc(H);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = 5; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic end_cs();
    waitc(H); cs_i = 1'b0; waitc(2 * H);
  endtask

  // scoreboard driver: push expected word, shift the read, push captured word
  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag, input int lead);
    logic [15:0] got;
    exp_q.push_back(exp); tag_q.push_back(tag);
    send_hdr(2'b10, a, lead);
    waitc(H);
    check(do_oe_o && !do_o, {tag, " dummy bit"}, {do_oe_o, do_o}, 2'b10);
    for (int i = 15; i >= 0; i--) begin
      sk_i = 1'b1; waitc(H); sk_i = 1'b0; waitc(H);
      got[i] = do_o;
    end
    cap_q.push_back(got);
    -> cap_ev;
    end_cs();
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    send_hdr(2'b01, a, 0); send_data(d); end_cs();
  endtask

  task automatic ext(input logic [1:0] sel);
    send_hdr(2'b00, {sel, 4'b1010}, 0); end_cs();
  endtask

  task automatic prog_wait(input string tag);
    int n = 0;
    cs_i = 1'b1; waitc(H);
    check(do_oe_o && !do_o, {tag, " busy status"}, {do_oe_o, do_o}, 2'b10);
    while (!(do_oe_o && do_o) && n < 3 * PROG) begin waitc(1); n++; end
    check(do_oe_o && do_o, {tag, " ready status"}, {do_oe_o, do_o}, 2'b11);
    cs_i = 1'b0; waitc(2 * H);
  endtask

  task automatic no_status(input string tag);
    cs_i = 1'b1; waitc(H);
    check(!do_oe_o, tag, do_oe_o, 0);
    cs_i = 1'b0; waitc(2 * H);
  endtask

  // monitor: pop expected and captured words and compare
  initial forever begin
    @(cap_ev);
    while (cap_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g, e;
      string t;
      g = cap_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    waitc(5); rst_ni = 1'b1; waitc(5);
    check(!do_oe_o, "R1 reset oe low", do_oe_o, 0);
    no_status("R1 no status after reset");
    rd(6'd3, 16'hFFFF, "R1 word 3 erased", 0);

    // R4: writes ignored while disabled
    wr(6'd5, 16'h1234);
    no_status("R4 no busy while disabled");
    rd(6'd5, 16'hFFFF, "R4 word 5 unchanged", 0);

    ext(2'b11);
    no_status("R4 enable has no busy");
    wr(6'd5, 16'h1234);
    prog_wait("R3 write 5");
    rd(6'd5, 16'h1234, "R3 read back 5", 0);

    // R6/R7 busy and ready behaviour
    wr(6'd9, 16'hA5C3);
    cs_i = 1'b1; waitc(H);
    check(do_oe_o && !do_o, "R6 busy first look", {do_oe_o, do_o}, 2'b10);
    cs_i = 1'b0; waitc(H);
    check(!do_oe_o, "R8 oe low with cs low during busy", do_oe_o, 0);
    send_hdr(2'b10, 6'd5, 0);
    check(do_oe_o && !do_o, "R6 serial activity ignored while busy", {do_oe_o, do_o}, 2'b10);
    cs_i = 1'b0; waitc(2 * H);
    prog_wait("R6 after toggles");
    cs_i = 1'b1; waitc(H);
    check(do_oe_o && do_o, "R7 ready persists across toggle", {do_oe_o, do_o}, 2'b11);
    pulse(1'b1); waitc(H);
    check(!do_oe_o, "R7 start bit clears status", do_oe_o, 0);
    cs_i = 1'b0; waitc(2 * H);
    no_status("R7 status stays cleared");
    rd(6'd9, 16'hA5C3, "R6 toggles did not disturb write", 0);

    // R7: start bit of a read clears ready and begins the read
    wr(6'd12, 16'h8001);
    prog_wait("R3 write 12");
    rd(6'd12, 16'h8001, "R7 read after ready", 0);
    rd(6'd12, 16'h8001, "R10 leading zeros", 3);

    // R5
    send_hdr(2'b11, 6'd5, 0); end_cs();
    prog_wait("R5 erase");
    rd(6'd5, 16'hFFFF, "R5 erase word 5", 0);
    send_hdr(2'b00, 6'b010000, 0); send_data(16'h0F0F); end_cs();
    prog_wait("R5 write all");
    rd(6'd0, 16'h0F0F, "R5 write all word 0", 0);
    rd(6'd63, 16'h0F0F, "R5 write all word 63", 0);
    ext(2'b10);
    prog_wait("R5 erase all");
    rd(6'd9, 16'hFFFF, "R5 erase all word 9", 0);

    // R9: extra clock after last bit abandons the write
    send_hdr(2'b01, 6'd7, 0); send_data(16'h5555); pulse(1'b0); end_cs();
    no_status("R9 abandoned write no busy");
    rd(6'd7, 16'hFFFF, "R9 word 7 unchanged", 0);

    // R4 disable, R2 read while disabled
    wr(6'd20, 16'h2468);
    prog_wait("R3 write 20");
    ext(2'b00);
    wr(6'd20, 16'h1111);
    no_status("R4 disabled write no busy");
    send_hdr(2'b00, 6'b100000, 0); end_cs();
    no_status("R4 disabled erase all no busy");
    rd(6'd20, 16'h2468, "R2 read while disabled", 0);

    waitc(20);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule